// File: doc/BRIEF.md
# MDIO Management Master

This block is a hardware master for the Ethernet management channel between a MAC-side controller and a PHY. The host requests a single register access with a one-cycle start strobe. With it come a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then generates the management clock (MDC) from the system clock and builds the serial frame. It drives the MDIO line through an output and output-enable pair, and it samples the line through a separate input when the PHY answers.

Every frame opens with a run of driven ones. A start code, an opcode and the two addresses follow. A write then drives its turnaround and data. A read releases the line, looks for the PHY pulling it low at the end of the turnaround, and shifts in 16 bits. When that low level is missing, the master gives a burst of released clocks so the PHY can resynchronise, then finishes with an error flag and zero data. Every frame ends with one released idle clock. Completion is signalled by a one-cycle done pulse. The result stays on the outputs until the next accepted start.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `mdc_o` is 1, `mdio_oe_o` is 0 and `busy_o` is 0. After reset `done_o`, `err_o` and `rdata_o` are 0.
- R2: Each MDC half-period lasts `HALF_CLKS` system clocks. `mdio_o` and `mdio_oe_o` change only at the edge where MDC falls, so both hold across every rising edge.
- R3: MDC cycles 0 to 31 of a frame drive MDIO to 1 (output enable 1).
- R4: Cycles 32 and 33 drive the start code 0, 1. Cycles 34 and 35 drive the opcode: 1, 0 for a read and 0, 1 for a write.
- R5: Cycles 36 to 40 drive the PHY address and cycles 41 to 45 drive the register address, both MSB first.
- R6: On a write, cycles 46 and 47 drive 1 then 0. Cycles 48 to 63 drive the write data, MSB first.
- R7: On a write, cycle 64 has MDIO released (output enable 0), and the frame is exactly 65 MDC cycles long.
- R8: On a read, MDIO is released in cycles 46 and 47. The level on `mdio_i` at the end of the high half of cycle 47 decides success (0) or fault (1).
- R9: On a successful read, `mdio_i` is sampled at the end of the high half of each of cycles 48 to 63 and shifted in at the LSB, so cycle 48 lands in bit 15. One released cycle follows, for 65 cycles in all, and then `err_o` is 0.
- R10: On a turnaround fault, MDIO stays released for 32 resync cycles and then one idle cycle, for 81 cycles in all. The frame ends with `err_o` 1 and `rdata_o` 0.
- R11: `done_o` is high for exactly one system clock, on the edge where `busy_o` falls. `rdata_o` and `err_o` then hold until the next accepted start.
- R12: A start while `busy_o` is 1 is ignored, together with the address, data and select values presented with it. A start in the cycle where `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| rd_i | input | 1 | 1 selects a read, 0 a write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Data for a write |
| rdata_o | output | 16 | Data returned by a read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Frame in progress |
| err_o | output | 1 | Turnaround fault on the last read |
| mdc_o | output | 1 | Management clock to the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO level from the pad |

## Verification
Two events can land on the same clock edge: the done pulse that closes one frame, and the acceptance of the next start request. The bench provokes this by holding the start strobe high through a whole frame. The strobe is therefore present on every busy cycle, where it must be ignored, and also in the done cycle, where it must be accepted. The check is that exactly one done pulse appears in the first frame, that busy is high on the very next cycle, and that the first frame's captured bits match the expected ones. In a separate test a start pulse with altered inputs is injected mid-frame, and the serial stream must still match the original request.

// File: rtl/mdio_master_pkg.sv
`timescale 1ns/1ps
package mdio_master_pkg;

    // Sections of a management frame, in transmission order
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_WTA,
        PH_WDAT,
        PH_RTA,
        PH_RDAT,
        PH_RESYNC,
        PH_TAIL
    } phase_e;

endpackage

// File: rtl/mdio_half_tick.sv
`timescale 1ns/1ps
module mdio_half_tick #(
    parameter int HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            if (cnt_q == LAST) cnt_d = '0;
            else               cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && !restart_i && (cnt_q == LAST);
endmodule

// File: rtl/mdio_rx_shift.sv
`timescale 1ns/1ps
module mdio_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (clr_i)        data_d = '0;
        else if (shift_i) data_d = {data_q[DATA_W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_o = data_q;
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_master_pkg::*;
#(
    parameter int PHY_W      = 5,
    parameter int REG_W      = 5,
    parameter int DATA_W     = 16,
    parameter int PRE_LEN    = 32,
    parameter int RESYNC_LEN = 32,
    parameter int TAIL_LEN   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rd_i,
    input  logic [PHY_W-1:0] phy_i,
    input  logic [REG_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic             tick_i,
    input  logic             mdio_i,
    output logic             mdc_o,
    output logic             mdo_o,
    output logic             oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             restart_o,
    output logic             shift_o,
    output logic             clr_o
);
    localparam int HDR_LEN = 4 + PHY_W + REG_W;
    localparam int M1      = (PRE_LEN > RESYNC_LEN) ? PRE_LEN : RESYNC_LEN;
    localparam int M2      = (DATA_W > HDR_LEN) ? DATA_W : HDR_LEN;
    localparam int M3      = (M1 > M2) ? M1 : M2;
    localparam int MAXLEN  = (M3 > TAIL_LEN) ? M3 : TAIL_LEN;
    localparam int CNT_W   = $clog2(MAXLEN + 1);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [HDR_LEN-1:0] hdr;
        logic [DATA_W-1:0]  wd;
        logic               rd;
        logic               mdc;
        logic               mdo;
        logic               oe;
        logic               done;
        logic               err;
    } fsm_t;

    fsm_t s_d, s_q;
    logic [CNT_W-1:0] len;
    logic             last;

    // Length of the current section in MDC cycles
    always_comb begin
        unique case (s_q.ph)
            PH_PRE:    len = CNT_W'(PRE_LEN);
            PH_HDR:    len = CNT_W'(HDR_LEN);
            PH_WTA:    len = CNT_W'(2);
            PH_RTA:    len = CNT_W'(2);
            PH_WDAT:   len = CNT_W'(DATA_W);
            PH_RDAT:   len = CNT_W'(DATA_W);
            PH_RESYNC: len = CNT_W'(RESYNC_LEN);
            PH_TAIL:   len = CNT_W'(TAIL_LEN);
            default:   len = CNT_W'(1);
        endcase
    end

    assign last = (s_q.cnt == len - 1'b1);

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        restart_o = 1'b0;
        shift_o   = 1'b0;
        clr_o     = 1'b0;
        if (s_q.ph == PH_IDLE) begin
            if (start_i) begin
                s_d.ph    = PH_PRE;
                s_d.cnt   = '0;
                s_d.hdr   = {2'b01, (rd_i ? 2'b10 : 2'b01), phy_i, reg_i};
                s_d.wd    = wdata_i;
                s_d.rd    = rd_i;
                s_d.mdc   = 1'b0;
                s_d.mdo   = 1'b1;
                s_d.oe    = 1'b1;
                s_d.err   = 1'b0;
                restart_o = 1'b1;
                clr_o     = 1'b1;
            end
        end else if (tick_i) begin
            if (!s_q.mdc) begin
                s_d.mdc = 1'b1;                 // rising edge, data already stable
            end else begin
                // end of a bit cycle: fall MDC and present the next bit
                s_d.mdc = 1'b0;
                s_d.cnt = s_q.cnt + 1'b1;
                unique case (s_q.ph)
                    PH_PRE: if (last) begin
                        s_d.ph  = PH_HDR;
                        s_d.cnt = '0;
                        s_d.mdo = s_q.hdr[HDR_LEN-1];
                        s_d.hdr = s_q.hdr << 1;
                    end
                    PH_HDR: if (!last) begin
                        s_d.mdo = s_q.hdr[HDR_LEN-1];
                        s_d.hdr = s_q.hdr << 1;
                    end else begin
                        s_d.cnt = '0;
                        s_d.mdo = 1'b1;
                        if (s_q.rd) begin
                            s_d.ph = PH_RTA;
                            s_d.oe = 1'b0;
                        end else begin
                            s_d.ph = PH_WTA;
                        end
                    end
                    PH_WTA: if (!last) begin
                        s_d.mdo = 1'b0;
                    end else begin
                        s_d.ph  = PH_WDAT;
                        s_d.cnt = '0;
                        s_d.mdo = s_q.wd[DATA_W-1];
                        s_d.wd  = s_q.wd << 1;
                    end
                    PH_WDAT: if (!last) begin
                        s_d.mdo = s_q.wd[DATA_W-1];
                        s_d.wd  = s_q.wd << 1;
                    end else begin
                        s_d.ph  = PH_TAIL;
                        s_d.cnt = '0;
                        s_d.oe  = 1'b0;
                        s_d.mdo = 1'b1;
                    end
                    PH_RTA: if (last) begin
                        s_d.cnt = '0;
                        if (!mdio_i) begin
                            s_d.ph = PH_RDAT;
                        end else begin
                            s_d.ph  = PH_RESYNC;
                            s_d.err = 1'b1;
                        end
                    end
                    PH_RDAT: begin
                        shift_o = 1'b1;
                        if (last) begin
                            s_d.ph  = PH_TAIL;
                            s_d.cnt = '0;
                        end
                    end
                    PH_RESYNC: if (last) begin
                        s_d.ph  = PH_TAIL;
                        s_d.cnt = '0;
                    end
                    PH_TAIL: if (last) begin
                        s_d.ph   = PH_IDLE;
                        s_d.cnt  = '0;
                        s_d.mdc  = 1'b1;
                        s_d.done = 1'b1;
                    end
                    default: s_d.ph = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ph   <= PH_IDLE;
            s_q.mdc  <= 1'b1;
            s_q.mdo  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mdc_o  = s_q.mdc;
    assign mdo_o  = s_q.mdo;
    assign oe_o   = s_q.oe;
    assign busy_o = (s_q.ph != PH_IDLE);
    assign done_o = s_q.done;
    assign err_o  = s_q.err;
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
    parameter int HALF_CLKS  = 4,
    parameter int PHY_W      = 5,
    parameter int REG_W      = 5,
    parameter int DATA_W     = 16,
    parameter int PRE_LEN    = 32,
    parameter int RESYNC_LEN = 32,
    parameter int TAIL_LEN   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [PHY_W-1:0]  phy_addr_i,
    input  logic [REG_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    logic tick, restart, shift_en, clr;

    mdio_half_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy_o),
        .restart_i (restart),
        .tick_o    (tick)
    );

    mdio_frame_fsm #(
        .PHY_W      (PHY_W),
        .REG_W      (REG_W),
        .DATA_W     (DATA_W),
        .PRE_LEN    (PRE_LEN),
        .RESYNC_LEN (RESYNC_LEN),
        .TAIL_LEN   (TAIL_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rd_i      (rd_i),
        .phy_i     (phy_addr_i),
        .reg_i     (reg_addr_i),
        .wdata_i   (wdata_i),
        .tick_i    (tick),
        .mdio_i    (mdio_i),
        .mdc_o     (mdc_o),
        .mdo_o     (mdio_o),
        .oe_o      (mdio_oe_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .err_o     (err_o),
        .restart_o (restart),
        .shift_o   (shift_en),
        .clr_o     (clr)
    );

    mdio_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .shift_i (shift_en),
        .bit_i   (mdio_i),
        .data_o  (rdata_o)
    );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              mdc_o,
    input logic              mdio_o,
    input logic              mdio_oe_o
);
    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mdc_o && !mdio_oe_o));

    assert_stable_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    assert_fault_nodata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rdata_o == '0));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_accept_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .rdata_o   (rdata_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd = 1'b0;
    logic [4:0]  phy = '0;
    logic [4:0]  rg = '0;
    logic [15:0] wd = '0;
    logic        mdio_in = 1'b1;
    logic [15:0] rdata;
    logic        done, busy, err, mdc, mdo, oe;

    mdio_master #(.HALF_CLKS(H)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_i(rd),
        .phy_addr_i(phy), .reg_addr_i(rg), .wdata_i(wd),
        .rdata_o(rdata), .done_o(done), .busy_o(busy), .err_o(err),
        .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(oe), .mdio_i(mdio_in)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wd;
        logic [15:0] pd;
        logic        ta_ok;
    } vec_t;

    localparam vec_t VEC [7] = '{
        {1'b0, 5'h1F, 5'h00, 16'hA5C3, 16'h0000, 1'b1},
        {1'b0, 5'h00, 5'h1F, 16'h0001, 16'h0000, 1'b1},
        {1'b1, 5'h01, 5'h02, 16'h0000, 16'h8001, 1'b1},
        {1'b1, 5'h15, 5'h0A, 16'h0000, 16'hFFFF, 1'b1},
        {1'b1, 5'h1E, 5'h11, 16'h0000, 16'h1234, 1'b0},
        {1'b1, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b1},
        {1'b0, 5'h0A, 5'h15, 16'hFFFF, 16'h0000, 1'b1}
    };

    // Level the modelled PHY places on the line for bit cycle b
    function automatic bit phy_bit(input vec_t v, input int b);
        if (!v.rd)         return 1'b1;
        if (b == 47)       return v.ta_ok ? 1'b0 : 1'b1;
        if (b >= 48 && b < 64) return v.pd[63 - b];
        return 1'b1;
    endfunction

    // Expected pad state at the rising edge of bit cycle b
    task automatic exp_bit(input vec_t v, input int b, output bit e_oe, output bit e_mdo,
                           output string req);
        bit [13:0] hdr;
        hdr   = {2'b01, (v.rd ? 2'b10 : 2'b01), v.phy, v.rg};
        e_oe  = 1'b1;
        e_mdo = 1'b1;
        if (b < 32) begin
            req = "R3 preamble";
        end else if (b < 36) begin
            req = "R4 start/opcode";  e_mdo = hdr[45 - b];
        end else if (b < 46) begin
            req = "R5 addresses";     e_mdo = hdr[45 - b];
        end else if (!v.rd) begin
            if (b < 48)      begin req = "R6 write turnaround"; e_mdo = (b == 46); end
            else if (b < 64) begin req = "R6 write data";       e_mdo = v.wd[63 - b]; end
            else             begin req = "R7 write release";    e_oe = 1'b0; end
        end else begin
            e_oe = 1'b0;
            if (b < 48)         req = "R8 read turnaround released";
            else if (v.ta_ok)   req = "R9 read data/tail released";
            else                req = "R10 resync released";
        end
    endtask

    task automatic run_txn(input vec_t v, input int poke_at, input bit hold_start);
        bit    cap_oe[100];
        bit    cap_mdo[100];
        int    rises = 0, dones = 0, since = 0, viol = 0, badhalf = 0, clkn = 0, exp_n;
        bit    first = 1'b1;
        bit    pm, pmdo, poe, e_oe, e_mdo;
        string req;
        @(negedge clk);
        rd = v.rd; phy = v.phy; rg = v.rg; wd = v.wd; start = 1'b1;
        mdio_in = 1'b1;
        pm = mdc; pmdo = mdo; poe = oe;
        while (clkn < 6000) begin
            @(negedge clk);
            clkn++;
            if (!hold_start && clkn == 1) start = 1'b0;
            if (poke_at != 0 && clkn == poke_at) begin
                start = 1'b1; rd = ~v.rd; phy = ~v.phy; rg = ~v.rg; wd = ~v.wd;
            end
            if (poke_at != 0 && clkn == poke_at + 1) start = 1'b0;
            since++;
            if (mdc != pm) begin
                if (!first && since != H) badhalf++;
                first = 1'b0;
                since = 0;
                if (mdc) begin
                    if (mdo != pmdo || oe != poe) viol++;
                    if (rises < 100) begin cap_oe[rises] = oe; cap_mdo[rises] = mdo; end
                    rises++;
                end else begin
                    mdio_in = phy_bit(v, rises);
                end
            end
            pm = mdc; pmdo = mdo; poe = oe;
            if (done) begin
                dones++;
                chk(!busy, "R11 busy low in done cycle", int'(busy), 0);
                break;
            end
        end
        exp_n = (v.rd && !v.ta_ok) ? 81 : 65;
        chk(rises == exp_n, v.rd ? (v.ta_ok ? "R9 read length" : "R10 fault length")
                                 : "R7 write length", rises, exp_n);
        for (int b = 0; b < exp_n && b < rises && b < 100; b++) begin
            exp_bit(v, b, e_oe, e_mdo, req);
            chk(cap_oe[b] == e_oe && (!e_oe || cap_mdo[b] == e_mdo), req,
                int'({cap_oe[b], cap_mdo[b]}), int'({e_oe, e_mdo}));
        end
        chk(viol == 0, "R2 MDIO stable across MDC rise", viol, 0);
        chk(badhalf == 0, "R2 half-period length", badhalf, 0);
        chk(dones == 1, "R11 done seen once", dones, 1);
        chk(rdata == ((v.rd && v.ta_ok) ? v.pd : 16'h0),
            v.ta_ok ? "R9 read data" : "R10 no data on fault",
            int'(rdata), int'((v.rd && v.ta_ok) ? v.pd : 16'h0));
        chk(err == (v.rd && !v.ta_ok), "R10 error flag", int'(err), int'(v.rd && !v.ta_ok));
        rd = v.rd; phy = v.phy; rg = v.rg; wd = v.wd;
        @(negedge clk);
        mdio_in = 1'b1;
        if (hold_start) begin
            start = 1'b0;
            chk(busy && !done, "R12 start in done cycle accepted", int'({busy, done}), 2);
            clkn = 0;
            while (!done && clkn < 6000) begin @(negedge clk); clkn++; end
            chk(done && err == 1'b0, "R12 second frame completes", int'({done, err}), 2);
            @(negedge clk);
        end else begin
            chk(!done, "R11 done one cycle only", int'(done), 0);
            repeat (6) @(negedge clk);
            chk(rdata == ((v.rd && v.ta_ok) ? v.pd : 16'h0) && err == (v.rd && !v.ta_ok),
                "R11 result held", int'({err, rdata}),
                int'({(v.rd && !v.ta_ok), ((v.rd && v.ta_ok) ? v.pd : 16'h0)}));
        end
        chk(mdc && !oe && !busy, "R1 idle pins between frames", int'({mdc, oe, busy}), 4);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mdc && !oe && !busy && !done && !err && rdata == 16'h0, "R1 reset state",
            int'({mdc, oe, busy, done, err}), 16);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mdc && !oe && !busy, "R1 idle after reset", int'({mdc, oe, busy}), 4);

        for (int i = 0; i < 7; i++) run_txn(VEC[i], 0, 1'b0);

        // R12: start with altered inputs mid-frame, write then read
        run_txn(VEC[0], 200, 1'b0);
        run_txn(VEC[2], 300, 1'b0);
        // R12: start held through the frame, taken again in the done cycle
        run_txn(VEC[1], 0, 1'b1);

        finish_run();
    end
endmodule